// File: doc/BRIEF.md
# Two-Phase Accumulator Processor Core

This block is a minimal processor core. It alternates between fetching an instruction and executing it. It talks to a single-ported synchronous memory of 256 words of 12 bits. That memory has one cycle of read latency. Each instruction word has a 4-bit op-code in bits [11:8] and an 8-bit memory address in bits [7:0]. The core holds a program counter, an instruction register, four 8-bit general registers (A, B, C, D) and a carry flag.

The op-code is a structured field. The low pair of bits picks the register the instruction acts on. The high pair picks the operation: load, add or store. An all-zero op-code halts the core. During fetch the program counter drives the memory address. During execute the address field of the held instruction drives it.

Each phase lasts two cycles. The first cycle presents the address. The second cycle uses the word the memory returns. The phase, program counter, registers and carry are brought out as debug outputs.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o`, all four register outputs and `carry_o` are 0, `phase_o` is 0 (fetch-address), and `mem_we_o` and `halted_o` are 0.
- R2: `phase_o` steps through the codes 0 (fetch-address), 1 (fetch-data), 2 (execute-address) and 3 (execute-data), then returns to 0. From 2 it goes instead to 4 (halted) when the held op-code is 0000.
- R3: In phases 0 and 1, `mem_addr_o` equals `pc_o`. The instruction register takes `mem_rdata_i` in phase 1, and `pc_o` rises by one at the end of phase 1.
- R4: In phases 2 and 3, `mem_addr_o` equals bits [7:0] of the instruction fetched last.
- R5: Op-code bits [9:8] select the register: 11 selects A, 10 selects B, 01 selects C, 00 selects D. No more than one register changes per instruction, and registers change only at the end of phase 3.
- R6: Op-code bits [11:10] = 10 loads the selected register with bits [7:0] of the addressed memory word.
- R7: Bits [11:10] = 11 adds bits [7:0] of the addressed word to the selected register, modulo 256. `carry_o` takes the carry-out of that add. Other instructions leave `carry_o` unchanged.
- R8: Bits [11:10] = 01 writes the selected register to the addressed word, with the upper 4 bits zero.
- R9: Bits [11:10] = 00 with a non-zero select pair is a no-operation: no register, carry or memory word changes.
- R10: Op-code 0000 enters phase 4 and sets `halted_o`. After that, `pc_o` stays at the halt address plus one, the phase remains 4, and no memory write occurs until reset.
- R11: `mem_we_o` is high only in phase 2, and only for a store instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 8 | Memory address |
| mem_rdata_i | input | 12 | Memory read word, valid one cycle after its address |
| mem_wdata_o | output | 12 | Memory write word |
| mem_we_o | output | 1 | Memory write enable |
| phase_o | output | 3 | Current phase code |
| halted_o | output | 1 | Core halted |
| pc_o | output | 8 | Program counter |
| reg_a_o | output | 8 | Register A |
| reg_b_o | output | 8 | Register B |
| reg_c_o | output | 8 | Register C |
| reg_d_o | output | 8 | Register D |
| carry_o | output | 1 | Carry from the last add |

## Verification
The bench checks the decode mapping directly.
- Each select code is aimed at a known register. A reversed or shifted select decode would put values into the wrong register.
- An add whose sum passes 255 checks both the wrap and the carry. A load that follows it checks that the carry is kept.
- A store followed by a load of the same address shows whether the write landed and was zero-extended.
- A halt at address 0 catches a core that runs on past the halt or keeps counting.
- Random programs use memory words with non-zero upper bits. They are compared against an instruction-level model, which exposes a core that latches the read word a cycle early and so picks up stale data.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    PH_FETCH_ADDR = 3'd0,
    PH_FETCH_DATA = 3'd1,
    PH_EXEC_ADDR  = 3'd2,
    PH_EXEC_DATA  = 3'd3,
    PH_HALT       = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_STORE = 2'b01,
    OP_LOAD  = 2'b10,
    OP_ADD   = 2'b11
  } op_e;

  typedef struct packed {
    logic [3:0] reg_en;
    logic [1:0] sel;
    op_e        op;
    logic       halt;
  } dec_t;

endpackage

// File: rtl/acc_cpu_decoder.sv
module acc_cpu_decoder
  import acc_cpu_pkg::*;
#(
  parameter int OP_W = 4
) (
  input  logic [OP_W-1:0] opcode_i,
  output dec_t            dec_o
);

  always_comb begin
    dec_o.sel    = opcode_i[1:0];
    dec_o.op     = op_e'(opcode_i[3:2]);
    dec_o.reg_en = 4'b0001 << opcode_i[1:0];
    dec_o.halt   = (opcode_i == '0);
  end

endmodule

// File: rtl/acc_cpu_sequencer.sv
module acc_cpu_sequencer
  import acc_cpu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   halt_i,
  output phase_e phase_o
);

  phase_e phase_q, phase_d;

  always_comb begin
    unique case (phase_q)
      PH_FETCH_ADDR: phase_d = PH_FETCH_DATA;
      PH_FETCH_DATA: phase_d = PH_EXEC_ADDR;
      PH_EXEC_ADDR:  phase_d = halt_i ? PH_HALT : PH_EXEC_DATA;
      PH_EXEC_DATA:  phase_d = PH_FETCH_ADDR;
      default:       phase_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_FETCH_ADDR;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/acc_cpu_regfile.sv
module acc_cpu_regfile #(
  parameter int DATA_W = 8,
  parameter int NREG   = 4,
  localparam int SEL_W = $clog2(NREG)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_i,
  input  logic                         add_i,
  input  logic [NREG-1:0]              reg_en_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [DATA_W-1:0]            data_i,
  output logic [NREG-1:0][DATA_W-1:0]  regs_o,
  output logic [DATA_W-1:0]            sel_data_o,
  output logic                         carry_o
);

  logic [DATA_W:0] sum;

  assign sel_data_o = regs_o[sel_i];
  assign sum        = {1'b0, sel_data_o} + {1'b0, data_i};

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 regs_o[g] <= '0;
      else if (wr_i && reg_en_i[g]) regs_o[g] <= add_i ? sum[DATA_W-1:0] : data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            carry_o <= 1'b0;
    else if (wr_i && add_i) carry_o <= sum[DATA_W];
  end

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int OP_W   = 4,
  localparam int INSTR_W = OP_W + ADDR_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output logic [ADDR_W-1:0]  mem_addr_o,
  input  logic [INSTR_W-1:0] mem_rdata_i,
  output logic [INSTR_W-1:0] mem_wdata_o,
  output logic               mem_we_o,
  output logic [2:0]         phase_o,
  output logic               halted_o,
  output logic [ADDR_W-1:0]  pc_o,
  output logic [DATA_W-1:0]  reg_a_o,
  output logic [DATA_W-1:0]  reg_b_o,
  output logic [DATA_W-1:0]  reg_c_o,
  output logic [DATA_W-1:0]  reg_d_o,
  output logic               carry_o
);

  localparam int NREG = 4;

  phase_e                      phase;
  dec_t                        dec;
  logic [ADDR_W-1:0]           pc_q;
  logic [INSTR_W-1:0]          ir_q;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0]           sel_data;
  logic [NREG-1:0]             reg_en;
  logic                        exec_ph;
  logic                        reg_wr;

  acc_cpu_decoder #(.OP_W(OP_W)) u_dec (
    .opcode_i (ir_q[INSTR_W-1 -: OP_W]),
    .dec_o    (dec)
  );

  acc_cpu_sequencer u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .halt_i  (dec.halt),
    .phase_o (phase)
  );

  assign reg_en  = dec.reg_en;
  assign exec_ph = (phase == PH_EXEC_ADDR) || (phase == PH_EXEC_DATA);
  assign reg_wr  = (phase == PH_EXEC_DATA) && ((dec.op == OP_LOAD) || (dec.op == OP_ADD));

  acc_cpu_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr),
    .add_i      (dec.op == OP_ADD),
    .reg_en_i   (reg_en),
    .sel_i      (dec.sel),
    .data_i     (mem_rdata_i[DATA_W-1:0]),
    .regs_o     (regs),
    .sel_data_o (sel_data),
    .carry_o    (carry_o)
  );

  // fetch: PC increments as the instruction word is captured
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q <= '0;
      ir_q <= '0;
    end else if (phase == PH_FETCH_DATA) begin
      pc_q <= pc_q + 1'b1;
      ir_q <= mem_rdata_i;
    end
  end

  assign mem_addr_o  = exec_ph ? ir_q[ADDR_W-1:0] : pc_q;
  assign mem_we_o    = (phase == PH_EXEC_ADDR) && (dec.op == OP_STORE);
  assign mem_wdata_o = {{(INSTR_W-DATA_W){1'b0}}, sel_data};

  assign phase_o  = phase;
  assign halted_o = (phase == PH_HALT);
  assign pc_o     = pc_q;
  assign reg_a_o  = regs[3];
  assign reg_b_o  = regs[2];
  assign reg_c_o  = regs[1];
  assign reg_d_o  = regs[0];

endmodule

// File: rtl/acc_cpu_core_chk.sv
module acc_cpu_core_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int INSTR_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         phase_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               mem_we_o,
  input logic [ADDR_W-1:0]  pc_o,
  input logic [INSTR_W-1:0] ir_q,
  input logic [DATA_W-1:0]  reg_a_o,
  input logic [DATA_W-1:0]  reg_b_o,
  input logic [DATA_W-1:0]  reg_c_o,
  input logic [DATA_W-1:0]  reg_d_o,
  input logic               halted_o
);

  assert_fa_to_fd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0) |=> (phase_o == 3'd1));
  assert_fd_to_ea_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1) |=> (phase_o == 3'd2));
  assert_ea_next_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2) |=> (phase_o == 3'd3 || phase_o == 3'd4));
  assert_ed_to_fa_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd3) |=> (phase_o == 3'd0));

  assert_fetch_addr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd0 || phase_o == 3'd1) |-> (mem_addr_o == pc_o));
  assert_pc_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd1) |=> (pc_o == $past(pc_o) + 1'b1));

  assert_exec_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2 || phase_o == 3'd3) |-> (mem_addr_o == ir_q[ADDR_W-1:0]));

  assert_one_reg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd3) |=> ($countones({reg_a_o != $past(reg_a_o), reg_b_o != $past(reg_b_o),
                                       reg_c_o != $past(reg_c_o), reg_d_o != $past(reg_d_o)}) <= 1));
  assert_regs_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 3'd3) |=> ($stable(reg_a_o) && $stable(reg_b_o) && $stable(reg_c_o) && $stable(reg_d_o)));

  assert_halt_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |=> (halted_o && $stable(pc_o) && !mem_we_o));

  assert_we_phase_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (phase_o == 3'd2 && ir_q[INSTR_W-1 -: 2] == 2'b01));

endmodule

bind acc_cpu_core acc_cpu_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_o    (phase_o),
  .mem_addr_o (mem_addr_o),
  .mem_we_o   (mem_we_o),
  .pc_o       (pc_o),
  .ir_q       (ir_q),
  .reg_a_o    (reg_a_o),
  .reg_b_o    (reg_b_o),
  .reg_c_o    (reg_c_o),
  .reg_d_o    (reg_d_o),
  .halted_o   (halted_o)
);

// File: tb/tb_acc_cpu_core.sv
`timescale 1ns/1ps
module tb_acc_cpu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [11:0] mem_rdata = '0;
  logic [11:0] mem_wdata;
  logic        mem_we;
  logic [2:0]  phase;
  logic        halted;
  logic [7:0]  pc, ra, rb, rc, rd;
  logic        carry;

  always #2.5 clk = ~clk;

  acc_cpu_core dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata),
    .mem_wdata_o(mem_wdata), .mem_we_o(mem_we), .phase_o(phase), .halted_o(halted),
    .pc_o(pc), .reg_a_o(ra), .reg_b_o(rb), .reg_c_o(rc), .reg_d_o(rd), .carry_o(carry)
  );

  // bench memory, preloaded through ld_* while reset is held
  logic [11:0] mem [256];
  logic        ld_we = 1'b0;
  logic [7:0]  ld_addr = '0;
  logic [11:0] ld_data = '0;

  always @(posedge clk) begin
    if (ld_we)       mem[ld_addr] <= ld_data;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int n_checks = 0, n_fail = 0;
  int mon_checks = 0, mon_fail = 0;
  bit mon_en = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cycle monitor: R2 phase order, R3/R4 address source, R11 write enable
  logic [2:0]  prev_ph;
  bit          prev_ok = 1'b0;
  logic [11:0] last_ir = '0;

  always @(negedge clk) begin
    if (rst_n && mon_en) begin
      if (prev_ok) begin
        logic [2:0] nx;
        bit ok;
        nx = (prev_ph == 3'd4) ? 3'd4 : (prev_ph == 3'd3) ? 3'd0 : prev_ph + 3'd1;
        ok = (phase == nx) || (prev_ph == 3'd2 && phase == 3'd4 && last_ir[11:8] == 4'h0);
        if (prev_ph == 3'd2 && phase == 3'd3 && last_ir[11:8] == 4'h0) ok = 1'b0;
        mon_checks++;
        if (!ok) begin mon_fail++; $display("FAIL R2 actual=%0h expected=%0h", phase, nx); end
      end
      if (phase == 3'd0 || phase == 3'd1) begin
        mon_checks++;
        if (mem_addr != pc) begin mon_fail++; $display("FAIL R3 actual=%0h expected=%0h", mem_addr, pc); end
      end
      if (phase == 3'd1) last_ir = mem_rdata;
      if (phase == 3'd2 || phase == 3'd3) begin
        mon_checks++;
        if (mem_addr != last_ir[7:0]) begin mon_fail++; $display("FAIL R4 actual=%0h expected=%0h", mem_addr, last_ir[7:0]); end
      end
      mon_checks++;
      if (mem_we != (phase == 3'd2 && last_ir[11:10] == 2'b01)) begin
        mon_fail++;
        $display("FAIL R11 actual=%0h expected=%0h", mem_we, (phase == 3'd2 && last_ir[11:10] == 2'b01));
      end
      prev_ph = phase;
      prev_ok = 1'b1;
    end else begin
      prev_ok = 1'b0;
    end
  end

  // reference program image and instruction-level model
  logic [11:0] ref_mem [256];

  function automatic logic [7:0] dut_reg(input int i);
    case (i)
      3: return ra;
      2: return rb;
      1: return rc;
      default: return rd;
    endcase
  endfunction

  task automatic run_prog(input string name);
    logic [7:0]  m_pc;
    logic [7:0]  m_r [4];
    logic        m_c;
    logic [11:0] w;
    logic [8:0]  s;
    int          n_ins;
    bit          done;
    logic [7:0]  pc_hold;

    rst_n = 1'b0;
    mon_en = 1'b0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      ld_we = 1'b1; ld_addr = 8'(i); ld_data = ref_mem[i];
    end
    @(negedge clk);
    ld_we = 1'b0;
    chk(pc == 0 && ra == 0 && rb == 0 && rc == 0 && rd == 0 && carry == 0 &&
        phase == 0 && !mem_we && !halted, "R1 reset state",
        {pc, ra, rb, rc, phase, mem_we, halted, carry}, 32'h0);

    // model
    m_pc = '0; m_c = 1'b0; n_ins = 0;
    for (int i = 0; i < 4; i++) m_r[i] = '0;
    for (int k = 0; k < 256; k++) begin
      w = ref_mem[m_pc];
      m_pc = m_pc + 8'd1;
      n_ins++;
      if (w[11:8] == 4'h0) break;
      case (w[11:10])
        2'b01: ref_mem[w[7:0]] = {4'h0, m_r[w[9:8]]};
        2'b10: m_r[w[9:8]] = ref_mem[w[7:0]][7:0];
        2'b11: begin
          s = {1'b0, m_r[w[9:8]]} + {1'b0, ref_mem[w[7:0]][7:0]};
          m_r[w[9:8]] = s[7:0];
          m_c = s[8];
        end
        default: ;
      endcase
    end

    rst_n = 1'b1;
    mon_en = 1'b1;
    done = 1'b0;
    for (int c = 0; c < 4 * n_ins + 20; c++) begin
      @(negedge clk);
      if (halted) begin done = 1'b1; break; end
    end
    chk(done, {"R10 halt reached ", name}, done, 1);
    for (int i = 0; i < 4; i++)
      chk(dut_reg(i) == m_r[i], $sformatf("R5/R6/R7 reg%0d %s", i, name), dut_reg(i), m_r[i]);
    chk(carry == m_c, {"R7 carry ", name}, carry, m_c);
    chk(pc == m_pc, {"R3 pc after halt ", name}, pc, m_pc);
    for (int a = 128; a < 256; a++)
      if (mem[a] != ref_mem[a]) chk(1'b0, $sformatf("R8 mem[%0h] %s", a, name), mem[a], ref_mem[a]);
    chk(1'b1, {"R8 memory image ", name}, 0, 0);
    pc_hold = pc;
    repeat (8) @(negedge clk);
    chk(halted && phase == 3'd4 && pc == pc_hold, {"R10 frozen ", name}, {pc, phase}, {pc_hold, 3'd4});
    mon_en = 1'b0;
  endtask

  task automatic clear_image();
    for (int i = 0; i < 256; i++) ref_mem[i] = '0;
  endtask

  initial begin
    void'($urandom(32'hC0DE_1234));

    // directed: select decode, wrap/carry, store then load, nop, halt
    clear_image();
    ref_mem[8'h80] = 12'hAF0; ref_mem[8'h81] = 12'h320; ref_mem[8'h82] = 12'h57F;
    ref_mem[0] = 12'hB80;  // load A
    ref_mem[1] = 12'hF81;  // add A -> 0x10, carry
    ref_mem[2] = 12'h790;  // store A
    ref_mem[3] = 12'hA90;  // load B from stored word
    ref_mem[4] = 12'h1FF;  // nop
    ref_mem[5] = 12'h882;  // load D, carry kept
    ref_mem[6] = 12'hD81;  // add C -> 0x20, carry clear
    ref_mem[7] = 12'h000;
    run_prog("directed");
    chk(ra == 8'h10, "R6/R7 A wraps", ra, 8'h10);
    chk(rb == 8'h10, "R8 store/load B", rb, 8'h10);
    chk(rc == 8'h20, "R5 select C", rc, 8'h20);
    chk(rd == 8'h7F, "R6 select D", rd, 8'h7F);
    chk(carry == 1'b0, "R7 carry cleared", carry, 0);
    chk(mem[8'h90] == 12'h010, "R8 zero-extended", mem[8'h90], 12'h010);
    chk(mem[8'hFF] == 12'h000, "R9 nop no write", mem[8'hFF], 0);
    chk(pc == 8'd8, "R10 pc frozen at 8", pc, 8);

    // directed: carry kept by load and nop
    clear_image();
    ref_mem[8'h80] = 12'h0FF; ref_mem[8'h81] = 12'h001;
    ref_mem[0] = 12'hE80; ref_mem[1] = 12'hE81; ref_mem[2] = 12'hB81; ref_mem[3] = 12'h280;
    run_prog("carry keep");
    chk(carry == 1'b1 && rb == 8'h00 && ra == 8'h01, "R7 carry kept", {carry, rb, ra}, 17'h10001);

    // directed: immediate halt
    clear_image();
    ref_mem[1] = 12'hB80; ref_mem[8'h80] = 12'h055;
    run_prog("halt first");
    chk(pc == 8'd1 && ra == 8'h00, "R10 halt at 0", {pc, ra}, 16'h0100);

    // random programs
    for (int p = 0; p < 6; p++) begin
      int n;
      clear_image();
      n = 10 + int'($urandom % 10);
      for (int a = 128; a < 144; a++) ref_mem[a] = 12'($urandom);
      for (int i = 0; i < n; i++) begin
        logic [1:0] op, sel;
        op = 2'($urandom);
        sel = 2'($urandom);
        if (op == 2'b00 && sel == 2'b00) sel = 2'b01;
        ref_mem[i] = {op, sel, 4'h8, 4'($urandom)};
      end
      run_prog($sformatf("random%0d", p));
    end

    n_checks += mon_checks;
    n_fail += mon_fail;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(150000 * 5);
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_checks + mon_checks + 1, n_fail + mon_fail + 1);
    $finish;
  end

endmodule